// File: doc/BRIEF.md
# Four-Channel DAC Code Write Port

This block sits behind an 8-bit register write bus and turns two byte writes into one update of a 12-bit, four-channel DAC. The first write, to the low-code address, places the eight least significant code bits in a holding register. The second write, to the high-code address, carries the four most significant code bits and a two-bit channel number. That second write also starts the transfer. The holding register keeps its value across transfers, so software can send several updates that share a low byte by writing it only once.

The transfer goes out as a 16-bit serial word, most significant bit first, under an active-low chip select and a serial clock. The `busy` output stays high for the whole word. A high-code write that arrives while a word is pending or in flight is dropped. The DAC side has its own reset command, a bit in a control register write, which stops any transfer and clears the holding register. A board-wide reset command bit in the same register leaves the DAC side untouched. The `rst` port is the power-on reset.

Top module: `dac_update_port`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `busy`=0, `dac_cs_n`=1, `dac_sclk`=0 and `dac_sdo`=0. The low-code holding register resets to 0x00, so a first word sent without a low-code write carries 0x00 in bits 7:0.
- R2: When the bus samples a write to address 7 while idle, `busy` is still 0 one clock later. It is 1 from the second clock on, for exactly 32*HALF_DIV clocks (64 at the default HALF_DIV=2). `dac_cs_n` is low in exactly those clocks.
- R3: The word is shifted MSB first on `dac_sdo`. Bits 15:14 are write data bits 7:6 of the address-7 write (the channel). Bits 13:12 are 0. Bits 11:8 are that write's data bits 3:0. Bits 7:0 are the low-code holding register. `dac_sdo` does not change while `dac_sclk` is high.
- R4: `dac_sclk` is low whenever `dac_cs_n` is high. Each bit is low for HALF_DIV clocks and then high for HALF_DIV clocks, which gives 16 rising edges per word.
- R5: A write to address 7 while a word is pending or in flight is ignored. No second word follows, and `busy` stays low afterwards.
- R6: The low-code holding register (address 6, data bits 7:0) keeps its value across transfers until it is written again.
- R7: A write to address 6 during a transfer does not change the word in flight. The next word uses the new value.
- R8: Data bits 5:4 of an address-7 write have no effect on the word.
- R9: A write to address 0 with data bit 4 set is the DAC reset. From the next clock, `busy`=0, `dac_cs_n`=1 and `dac_sclk`=0, and the holding register is 0x00.
- R10: A write to address 0 with only data bit 5 set is the board reset. It neither stops a transfer in flight nor changes the holding register.
- R11: Writes to addresses other than 0, 6 and 7 have no effect on the word or on the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Write strobe, one clock per write |
| wr_addr | input | 4 | Register address of the write |
| wr_data | input | 8 | Write data byte |
| busy | output | 1 | High while a word is being shifted to the DAC |
| dac_cs_n | output | 1 | Active-low DAC chip select |
| dac_sclk | output | 1 | DAC serial clock, idle low, data taken on rising edge |
| dac_sdo | output | 1 | DAC serial data, MSB first |

## Verification
The hardest cases to reach are writes that land inside a word in flight. These are a second launch, a low-code rewrite, a board-reset command, a stray address and a DAC-reset command, each arriving while the serial clock is running. Each of these tasks runs a frame capture alongside a delayed writer. The writer strikes about ten clocks into the word. The captured word and the busy length are then compared with the undisturbed word, or, for the DAC reset, the stopped outputs are checked. A follow-up launch with no low-code write then exposes the state of the holding register at the pins.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;

  // serial clock phase of the bit being shifted
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } sclk_phase_e;

  localparam int BUS_W = 8;

endpackage

// File: rtl/dac_wr_decode.sv
module dac_wr_decode
  import dac_if_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int LO_ADDR     = 6,
  parameter int HI_ADDR     = 7,
  parameter int CTRL_ADDR   = 0,
  parameter int DAC_RST_BIT = 4,
  parameter int CODE_W      = 12,
  parameter int CH_W        = 2,
  parameter int PAD_W       = 2,
  localparam int FRAME_W    = CH_W + PAD_W + CODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [BUS_W-1:0]   wr_data,
  input  logic               busy,
  output logic               launch,
  output logic [FRAME_W-1:0] frame,
  output logic               dac_clr
);

  localparam int HI_W = CODE_W - BUS_W;
  localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] HI_A   = ADDR_W'(HI_ADDR);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic [BUS_W-1:0] lo_q;
  logic             hi_wr;
  logic             lo_wr;

  assign dac_clr = wr_en && (wr_addr == CTRL_A) && wr_data[DAC_RST_BIT];
  assign lo_wr   = wr_en && (wr_addr == LO_A);
  assign hi_wr   = wr_en && (wr_addr == HI_A) && !busy && !launch;

  always_ff @(posedge clk) begin
    if (rst || dac_clr) begin
      lo_q   <= '0;
      launch <= 1'b0;
      frame  <= '0;
    end else begin
      launch <= 1'b0;
      if (lo_wr) begin
        lo_q <= wr_data;
      end
      if (hi_wr) begin
        launch <= 1'b1;
        frame  <= {wr_data[BUS_W-1 -: CH_W], {PAD_W{1'b0}}, wr_data[HI_W-1:0], lo_q};
      end
    end
  end

endmodule

// File: rtl/dac_frame_shifter.sv
module dac_frame_shifter
  import dac_if_pkg::*;
#(
  parameter int FRAME_W  = 16,
  parameter int HALF_DIV = 2,
  localparam int DIV_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1,
  localparam int BIT_W   = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic               active,
  output logic               sclk,
  output logic               sdo
);

  logic [FRAME_W-1:0] shreg;
  logic [DIV_W-1:0]   div_cnt;
  logic [BIT_W-1:0]   bit_cnt;
  sclk_phase_e        phase;
  logic               div_end;
  logic               last_bit;

  assign div_end  = (div_cnt == DIV_W'(HALF_DIV - 1));
  assign last_bit = (bit_cnt == BIT_W'(FRAME_W - 1));

  always_ff @(posedge clk) begin
    if (clr) begin
      active  <= 1'b0;
      shreg   <= '0;
      div_cnt <= '0;
      bit_cnt <= '0;
      phase   <= PH_LOW;
    end else if (!active) begin
      if (start) begin
        active  <= 1'b1;
        shreg   <= frame;
        div_cnt <= '0;
        bit_cnt <= '0;
        phase   <= PH_LOW;
      end
    end else begin
      div_cnt <= div_end ? '0 : div_cnt + 1'b1;
      if (div_end) begin
        if (phase == PH_LOW) begin
          phase <= PH_HIGH;
        end else begin
          phase <= PH_LOW;
          if (last_bit) begin
            active <= 1'b0;
            shreg  <= '0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            shreg   <= {shreg[FRAME_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sclk = (phase == PH_HIGH);
  assign sdo  = shreg[FRAME_W-1];

endmodule

// File: rtl/dac_update_port.sv
module dac_update_port #(
  parameter int ADDR_W      = 4,
  parameter int LO_ADDR     = 6,
  parameter int HI_ADDR     = 7,
  parameter int CTRL_ADDR   = 0,
  parameter int DAC_RST_BIT = 4,
  parameter int CODE_W      = 12,
  parameter int CH_W        = 2,
  parameter int PAD_W       = 2,
  parameter int HALF_DIV    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              busy,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_sdo
);

  localparam int FRAME_W = CH_W + PAD_W + CODE_W;

  logic               launch;
  logic [FRAME_W-1:0] frame;
  logic               dac_clr;
  logic               active;

  dac_wr_decode #(
    .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR),
    .CTRL_ADDR(CTRL_ADDR), .DAC_RST_BIT(DAC_RST_BIT),
    .CODE_W(CODE_W), .CH_W(CH_W), .PAD_W(PAD_W)
  ) u_decode (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(active), .launch(launch),
    .frame(frame), .dac_clr(dac_clr)
  );

  dac_frame_shifter #(
    .FRAME_W(FRAME_W), .HALF_DIV(HALF_DIV)
  ) u_shift (
    .clk(clk), .clr(rst | dac_clr), .start(launch), .frame(frame),
    .active(active), .sclk(dac_sclk), .sdo(dac_sdo)
  );

  assign busy     = active;
  assign dac_cs_n = ~active;

endmodule

// File: rtl/dac_update_port_chk.sv
module dac_update_port_chk #(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int FRAME_W   = 16,
  parameter int HALF_DIV  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              clr_bit,
  input logic              busy,
  input logic              dac_cs_n,
  input logic              dac_sclk,
  input logic              dac_sdo
);

  localparam int FRAME_CYC = 2 * HALF_DIV * FRAME_W;
  localparam int LEN_W     = $clog2(FRAME_CYC + 2) + 1;

  logic             dac_cmd;
  logic [LEN_W-1:0] busy_len;

  assign dac_cmd = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR)) && clr_bit;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_len <= '0;
    else              busy_len <= busy_len + 1'b1;
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    dac_cs_n |-> !dac_sclk); // R4

  AST_SDO_HELD_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
    dac_sclk |-> $stable(dac_sdo)); // R3

  AST_BUSY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_en, 2)); // R2

  AST_FULL_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(dac_cmd)) |-> (busy_len == LEN_W'(FRAME_CYC))); // R2

  AST_DAC_RESET_STOPS: assert property (@(posedge clk) disable iff (rst)
    dac_cmd |=> (!busy && dac_cs_n && !dac_sclk)); // R9

endmodule

bind dac_update_port dac_update_port_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
  .FRAME_W(CH_W + PAD_W + CODE_W), .HALF_DIV(HALF_DIV)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .clr_bit(wr_data[DAC_RST_BIT]), .busy(busy), .dac_cs_n(dac_cs_n),
  .dac_sclk(dac_sclk), .dac_sdo(dac_sdo)
);

// File: tb/dac_update_port_test.sv
`timescale 1ns/1ps
module dac_update_port_test;

  localparam int HALF  = 2;
  localparam int CYC   = 32 * HALF;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       busy, dac_cs_n, dac_sclk, dac_sdo;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dac_update_port #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .dac_cs_n(dac_cs_n),
    .dac_sclk(dac_sclk), .dac_sdo(dac_sdo)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // call right after the launching bus_write returns
  task automatic run_frame(input logic [15:0] exp, input string req);
    logic [15:0] word = '0;
    int len = 0, rises = 0, highs = 0;
    bit prev = 1'b0;
    check(busy == 1'b0, "R2", busy, 0);
    @(negedge clk);
    check(busy == 1'b1 && dac_cs_n == 1'b0, "R2", busy, 1);
    while (busy) begin
      len++;
      if (dac_cs_n) begin
        check(0, "R2", dac_cs_n, 0);
      end
      if (dac_sclk) highs++;
      if (dac_sclk && !prev) begin
        rises++;
        word = {word[14:0], dac_sdo};
      end
      prev = dac_sclk;
      @(negedge clk);
    end
    check(len == CYC, "R2", len, CYC);
    check(rises == 16 && highs == 16 * HALF, "R4", rises, 16);
    check(word == exp, req, word, exp);
    check(dac_cs_n && !dac_sclk, "R4", dac_sclk, 0);
  endtask

  task automatic t_reset();
    check(!busy && dac_cs_n && !dac_sclk && !dac_sdo, "R1", busy, 0);
    bus_write(4'd7, 8'hC5);
    run_frame(16'hC500, "R1");
  endtask

  task automatic t_basic();
    bus_write(4'd6, 8'hA7);
    bus_write(4'd7, 8'h4B);
    run_frame(16'h4BA7, "R3");
  endtask

  task automatic t_pad_and_keep();
    bus_write(4'd7, 8'hF2);
    run_frame(16'hC2A7, "R8 R6");
  endtask

  task automatic t_busy_writes();
    bus_write(4'd6, 8'h11);
    bus_write(4'd7, 8'h83);
    fork
      run_frame(16'h8311, "R7");
      begin
        repeat (10) @(negedge clk);
        bus_write(4'd6, 8'h22);
        bus_write(4'd7, 8'h4F);
      end
    join
    repeat (8) @(negedge clk);
    check(!busy && dac_cs_n, "R5", busy, 0);
    bus_write(4'd7, 8'h00);
    run_frame(16'h0022, "R7");
  endtask

  task automatic t_board_cmd();
    bus_write(4'd7, 8'h41);
    fork
      run_frame(16'h4122, "R10");
      begin
        repeat (10) @(negedge clk);
        bus_write(4'd0, 8'h20);
        bus_write(4'd3, 8'hFF);
        bus_write(4'd9, 8'h5A);
      end
    join
    bus_write(4'd7, 8'h00);
    run_frame(16'h0022, "R11");
  endtask

  task automatic t_dac_reset();
    bus_write(4'd7, 8'hC3);
    repeat (12) @(negedge clk);
    check(busy == 1'b1, "R9", busy, 1);
    bus_write(4'd0, 8'h10);
    check(!busy && dac_cs_n && !dac_sclk, "R9", busy, 0);
    repeat (4) @(negedge clk);
    check(!busy && dac_cs_n, "R9", busy, 0);
    bus_write(4'd7, 8'h00);
    run_frame(16'h0000, "R9");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(!busy && dac_cs_n && !dac_sclk && !dac_sdo, "R1", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_pad_and_keep();
    t_busy_writes();
    t_board_cmd();
    t_dac_reset();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule